// File: doc/BRIEF.md
# Serial Flash Read-Path Engine

This block is the slave side of a serial flash port, limited to the instructions that return data. A system clock oversamples the chip-select, serial clock and serial data-in pins. The block shifts in an 8-bit instruction, then a 24-bit address when the instruction needs one, and then the dummy clocks that instruction calls for. After that it streams bytes out of a small register-held array. The instruction set covers a plain read, a fast read, a two-line read and two identification reads. The output lines are released as soon as chip select goes high.

The array is filled at reset with a computed pattern so that every location is distinct. Program, erase, status writes and hold are handled by neighbouring logic. Neighbouring logic reports a running program or erase cycle through `busy_i`. The serial clock must stay at each level for at least three system clocks.

Top module: `sflash_read_engine`

## Requirements
- R1: After reset, and within four system clocks of chip select going high at any point, both output enables are low. Raising chip select ends the instruction and clears the bit count, so the next low period starts with a new instruction.
- R2: Serial clock idle low and idle high are both accepted. Inputs are taken on the rising edge, and the output lines change only in response to a falling edge.
- R3: Opcode 03h is a plain read. The instruction and the 24-bit address travel most significant bit first. The first data bit is driven on the falling edge after the last address bit, on `dq1_o`, most significant bit first. After reset, the array byte at address a equals the low eight bits of a XOR 5Ah.
- R4: Opcode 0Bh is a fast read. It takes FAST_DUMMY (8) clocks between the last address bit and the first data bit.
- R5: Opcode 3Bh is a two-line read. It takes DUAL_DUMMY (4) clocks and then two bits per clock. Bits 7, 5, 3 and 1 go on `dq1_o`, and bits 6, 4, 2 and 0 go on `dq0_o` with `dq0_oe_o` high.
- R6: A read continues for as long as clocks arrive. The address steps by one after each byte, and from the top address (2^ADDR_BITS-1) it wraps to zero.
- R7: Address bits above ADDR_BITS are ignored.
- R8: Opcode 9Fh needs no address. It returns 20h followed by 10h (TOP_BOOT=0) or 20h (TOP_BOOT=1), and the pair repeats while clocks continue.
- R9: Opcode ABh needs no address. It returns 05h, and the byte repeats while clocks continue.
- R10: When `busy_i` is high as the eighth instruction bit arrives, 9Fh and ABh are not decoded, and no output is driven until chip select rises.
- R11: Any other opcode is ignored, and no output is driven until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk_i | input | 1 | Serial clock pin |
| spi_csn_i | input | 1 | Active-low chip select pin |
| dq0_i | input | 1 | Serial data in (line 0) |
| busy_i | input | 1 | Program or erase cycle running |
| dq0_o | output | 1 | Line 0 output value, used by two-line read |
| dq0_oe_o | output | 1 | Line 0 output enable |
| dq1_o | output | 1 | Serial data out (line 1) value |
| dq1_oe_o | output | 1 | Line 1 output enable; low means high impedance |

## Verification
Two functions can land in the same cycle. One is the byte-boundary fetch on a falling edge, which advances the address and may wrap it to zero. The other is the release of chip select that follows that falling edge in idle-low mode. Reads are started just below the top address so that the wrap falls in the middle of a stream. Each idle-low transfer ends with a closing falling edge that loads a new byte just before chip select rises. The bench judges the result by checking that the enables drop and that the following instruction decodes from a clean bit count and returns the bytes it should.

// File: rtl/sfr_pkg.sv
// Shared definitions for the serial flash read-path engine: opcodes,
// identification bytes, phase and instruction encodings, and the decoder.
// Assumes 8-bit instructions and a 24-bit address phase.
package sfr_pkg;

    localparam int CMD_BITS  = 8;
    localparam int ADDR_BITS_WIRE = 24;
    localparam int BYTE_BITS = 8;

    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_FAST = 8'h0B;
    localparam logic [7:0] OPC_DUAL = 8'h3B;
    localparam logic [7:0] OPC_JID  = 8'h9F;
    localparam logic [7:0] OPC_SIG  = 8'hAB;

    localparam logic [7:0] ID_MAKER  = 8'h20;
    localparam logic [7:0] ID_BOTTOM = 8'h10;
    localparam logic [7:0] ID_TOP    = 8'h20;
    localparam logic [7:0] SIG_VALUE = 8'h05;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_IGNORE
    } phase_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_READ,
        OP_FAST,
        OP_DUAL,
        OP_JID,
        OP_SIG
    } op_t;

    // Maps a received instruction byte onto the internal instruction kind.
    function automatic op_t decode_op(input logic [7:0] code);
        case (code)
            OPC_READ: return OP_READ;
            OPC_FAST: return OP_FAST;
            OPC_DUAL: return OP_DUAL;
            OPC_JID:  return OP_JID;
            OPC_SIG:  return OP_SIG;
            default:  return OP_NONE;
        endcase
    endfunction

    // True for the instructions that take an address and read the array.
    function automatic logic op_is_array(input op_t op);
        return (op == OP_READ) || (op == OP_FAST) || (op == OP_DUAL);
    endfunction

endpackage

// File: rtl/sfr_pin_sync.sv
// Brings the serial pins into the system clock domain through STAGES flops
// and derives one-cycle pulses for serial clock rising and falling edges.
// Assumes each serial clock level lasts at least STAGES+1 system clocks.
// Data-in goes through the same depth, so it lines up with the edge pulses.
module sfr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic csn_o,
    output logic mosi_o
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] csn_q;
    logic [STAGES-1:0] mosi_q;
    logic              sclk_d;

    // Synchroniser chains plus one delayed copy of the clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
            csn_q  <= {csn_q[STAGES-2:0], csn_i};
            mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
            sclk_d <= sclk_q[TOP];
        end
    end

    // Edge pulses and synchronised levels.
    always_comb begin
        rise_o = sclk_q[TOP] & ~sclk_d;
        fall_o = ~sclk_q[TOP] & sclk_d;
        csn_o  = csn_q[TOP];
        mosi_o = mosi_q[TOP];
    end

endmodule

// File: rtl/sfr_array.sv
// Register-held data array, 2**ADDR_BITS bytes, with a combinational read
// port. Reset fills each location with its low address byte XOR FILL_KEY.
// Assumes the array is only read here; writes belong to other logic.
module sfr_array #(
    parameter int         ADDR_BITS = 8,
    parameter logic [7:0] FILL_KEY  = 8'h5A
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_BITS-1:0] addr_i,
    output logic [7:0]           rdata_o
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [7:0] cells [DEPTH];

    // Reset load of the computed pattern; contents hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'(i) ^ FILL_KEY;
            end
        end
    end

    // Asynchronous read of the addressed byte.
    always_comb rdata_o = cells[addr_i];

endmodule

// File: rtl/sfr_cmd_ctrl.sv
// Instruction and address front end. It counts rising edges while chip
// select is low, assembles the instruction, shifts the address (keeping
// only the low ADDR_BITS), counts the per-instruction dummy clocks and
// enters the data phase. During data it advances the address or the
// identification index on each byte fetch from the output driver.
// Assumes the synchronised chip select clears all per-instruction state.
module sfr_cmd_ctrl
    import sfr_pkg::*;
#(
    parameter int ADDR_BITS  = 8,
    parameter bit TOP_BOOT   = 1'b0,
    parameter int FAST_DUMMY = 8,
    parameter int DUAL_DUMMY = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_i,
    input  logic                 csn_i,
    input  logic                 mosi_i,
    input  logic                 busy_i,
    input  logic                 take_i,
    input  logic [7:0]           mem_rdata_i,
    output logic [ADDR_BITS-1:0] addr_o,
    output logic                 data_o,
    output logic                 dual_o,
    output logic [7:0]           byte_o
);

    localparam int CNT_W = $clog2(ADDR_BITS_WIRE + 1);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_BITS_WIRE - 1);
    localparam logic [CNT_W-1:0] FAST_LAST  = CNT_W'(FAST_DUMMY - 1);
    localparam logic [CNT_W-1:0] DUAL_LAST  = CNT_W'(DUAL_DUMMY - 1);
    localparam logic [7:0]       ID_SECOND  = TOP_BOOT ? ID_TOP : ID_BOTTOM;

    phase_t               phase_q;
    op_t                  op_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [7:0]           cmd_q;
    logic [ADDR_BITS-1:0] addr_q;
    logic                 id_sel_q;

    logic [7:0]       cmd_next;
    op_t              dec_op;
    logic [CNT_W-1:0] dummy_last;

    // Next instruction byte, its decode, and the dummy length for this read.
    always_comb begin
        cmd_next   = {cmd_q[6:0], mosi_i};
        dec_op     = decode_op(cmd_next);
        dummy_last = (op_q == OP_FAST) ? FAST_LAST : DUAL_LAST;
    end

    // Phase sequencing, bit counting, address capture and stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_CMD;
            op_q     <= OP_NONE;
            cnt_q    <= '0;
            cmd_q    <= '0;
            addr_q   <= '0;
            id_sel_q <= 1'b0;
        end else if (csn_i) begin
            phase_q  <= PH_CMD;
            cnt_q    <= '0;
            cmd_q    <= '0;
            id_sel_q <= 1'b0;
        end else begin
            if (rise_i) begin
                case (phase_q)
                    PH_CMD: begin
                        cmd_q <= cmd_next;
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CMD_LAST) begin
                            cnt_q <= '0;
                            op_q  <= dec_op;
                            case (dec_op)
                                OP_READ, OP_FAST, OP_DUAL: phase_q <= PH_ADDR;
                                OP_JID, OP_SIG: phase_q <= busy_i ? PH_IGNORE : PH_DATA;
                                default: phase_q <= PH_IGNORE;
                            endcase
                        end
                    end
                    PH_ADDR: begin
                        addr_q <= {addr_q[ADDR_BITS-2:0], mosi_i};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == ADDR_LAST) begin
                            cnt_q   <= '0;
                            phase_q <= (op_q == OP_READ) ? PH_DATA : PH_DUMMY;
                        end
                    end
                    PH_DUMMY: begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == dummy_last) begin
                            cnt_q   <= '0;
                            phase_q <= PH_DATA;
                        end
                    end
                    default: begin
                    end
                endcase
            end
            if (take_i && phase_q == PH_DATA) begin
                if (op_is_array(op_q)) begin
                    addr_q <= addr_q + 1'b1;
                end else begin
                    id_sel_q <= ~id_sel_q;
                end
            end
        end
    end

    // Byte offered to the output driver for the current instruction.
    always_comb begin
        case (op_q)
            OP_JID:  byte_o = id_sel_q ? ID_SECOND : ID_MAKER;
            OP_SIG:  byte_o = SIG_VALUE;
            default: byte_o = mem_rdata_i;
        endcase
        addr_o = addr_q;
        data_o = (phase_q == PH_DATA);
        dual_o = (op_q == OP_DUAL);
    end

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !csn_i && phase_q == PH_DATA && op_is_array(op_q) && addr_q == '1)
        |=> (addr_q == '0)); // R6

    AST_ID_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !csn_i && phase_q == PH_CMD && cnt_q == CMD_LAST && busy_i
         && (dec_op == OP_JID || dec_op == OP_SIG))
        |=> (phase_q == PH_IGNORE)); // R10

    AST_CS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> (phase_q == PH_CMD && cnt_q == '0)); // R1

endmodule

// File: rtl/sfr_out_drv.sv
// Output shifter. On each serial clock falling edge in the data phase it
// either fetches a new byte (pulsing take_o so the front end steps on) or
// shifts the held byte by one bit (single line) or two bits (two lines).
// Odd bits leave on line 1 and even bits on line 0 in two-line mode.
// Assumes chip select high drops both enables and restarts the byte count.
module sfr_out_drv
    import sfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_i,
    input  logic       csn_i,
    input  logic       active_i,
    input  logic       dual_i,
    input  logic [7:0] byte_i,
    output logic       take_o,
    output logic       dq1_o,
    output logic       dq1_oe_o,
    output logic       dq0_o,
    output logic       dq0_oe_o
);

    localparam int RW = $clog2(BYTE_BITS);
    localparam logic [RW-1:0] SINGLE_LAST = RW'(BYTE_BITS - 1);
    localparam logic [RW-1:0] DUAL_LAST   = RW'(BYTE_BITS / 2 - 1);

    logic [7:0]    sh_q;
    logic [RW-1:0] rem_q;
    logic          dq1_q, dq0_q, oe1_q, oe0_q, take_q;

    // Byte fetch, shifting and enable control, all on falling-edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rem_q  <= '0;
            dq1_q  <= 1'b0;
            dq0_q  <= 1'b0;
            oe1_q  <= 1'b0;
            oe0_q  <= 1'b0;
            take_q <= 1'b0;
        end else begin
            take_q <= 1'b0;
            if (csn_i) begin
                oe1_q <= 1'b0;
                oe0_q <= 1'b0;
                rem_q <= '0;
            end else if (fall_i && active_i) begin
                oe1_q <= 1'b1;
                oe0_q <= dual_i;
                if (rem_q == '0) begin
                    dq1_q  <= byte_i[7];
                    dq0_q  <= byte_i[6];
                    sh_q   <= dual_i ? {byte_i[5:0], 2'b00} : {byte_i[6:0], 1'b0};
                    rem_q  <= dual_i ? DUAL_LAST : SINGLE_LAST;
                    take_q <= 1'b1;
                end else begin
                    dq1_q <= sh_q[7];
                    dq0_q <= sh_q[6];
                    sh_q  <= dual_i ? {sh_q[5:0], 2'b00} : {sh_q[6:0], 1'b0};
                    rem_q <= rem_q - 1'b1;
                end
            end
        end
    end

    // Registered pin values.
    always_comb begin
        take_o   = take_q;
        dq1_o    = dq1_q;
        dq0_o    = dq0_q;
        dq1_oe_o = oe1_q;
        dq0_oe_o = oe0_q;
    end

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> (!dq1_oe_o && !dq0_oe_o)); // R1

    AST_DQ1_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(dq1_o)); // R2

    AST_DQ0_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_i |=> $stable(dq0_o)); // R2

    AST_DUAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        dq0_oe_o |-> dq1_oe_o); // R5

endmodule

// File: rtl/sflash_read_engine.sv
// Top of the serial flash read path: pin synchroniser, instruction front
// end, register array and output shifter. Outputs are value/enable pairs;
// the pad ring turns a low enable into high impedance.
// Assumes ADDR_BITS >= 2 and dummy counts between 1 and 24.
module sflash_read_engine #(
    parameter int         ADDR_BITS   = 8,
    parameter bit         TOP_BOOT    = 1'b0,
    parameter int         FAST_DUMMY  = 8,
    parameter int         DUAL_DUMMY  = 4,
    parameter logic [7:0] FILL_KEY    = 8'h5A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk_i,
    input  logic spi_csn_i,
    input  logic dq0_i,
    input  logic busy_i,
    output logic dq0_o,
    output logic dq0_oe_o,
    output logic dq1_o,
    output logic dq1_oe_o
);

    logic                 rise, fall, csn_s, mosi_s;
    logic                 take, data_act, dual;
    logic [ADDR_BITS-1:0] addr;
    logic [7:0]           mem_rdata, out_byte;

    sfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (spi_sclk_i),
        .csn_i  (spi_csn_i),
        .mosi_i (dq0_i),
        .rise_o (rise),
        .fall_o (fall),
        .csn_o  (csn_s),
        .mosi_o (mosi_s)
    );

    sfr_cmd_ctrl #(
        .ADDR_BITS  (ADDR_BITS),
        .TOP_BOOT   (TOP_BOOT),
        .FAST_DUMMY (FAST_DUMMY),
        .DUAL_DUMMY (DUAL_DUMMY)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .csn_i       (csn_s),
        .mosi_i      (mosi_s),
        .busy_i      (busy_i),
        .take_i      (take),
        .mem_rdata_i (mem_rdata),
        .addr_o      (addr),
        .data_o      (data_act),
        .dual_o      (dual),
        .byte_o      (out_byte)
    );

    sfr_array #(
        .ADDR_BITS (ADDR_BITS),
        .FILL_KEY  (FILL_KEY)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .rdata_o (mem_rdata)
    );

    sfr_out_drv u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_i   (fall),
        .csn_i    (csn_s),
        .active_i (data_act),
        .dual_i   (dual),
        .byte_i   (out_byte),
        .take_o   (take),
        .dq1_o    (dq1_o),
        .dq1_oe_o (dq1_oe_o),
        .dq0_o    (dq0_o),
        .dq0_oe_o (dq0_oe_o)
    );

endmodule

// File: tb/sflash_read_engine_bench.sv
`timescale 1ns/1ps
module sflash_read_engine_bench;

    localparam int         HALF  = 8;
    localparam logic [7:0] KEY   = 8'h5A;
    localparam int         AMASK = 8'hFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic csn = 1'b1;
    logic mosi = 1'b0;
    logic busy = 1'b0;
    logic dq0, dq0_oe, dq1, dq1_oe;

    int checks = 0;
    int failures = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic       mon_en = 1'b0;
    logic       mon_dual = 1'b0;
    int         mon_bits = 0;
    logic [7:0] mon_sh = '0;
    logic       mon_oe_bad = 1'b0;

    always #2.5 clk = ~clk;

    sflash_read_engine #(
        .ADDR_BITS(8), .TOP_BOOT(1'b0), .FAST_DUMMY(8), .DUAL_DUMMY(4),
        .FILL_KEY(KEY), .SYNC_STAGES(2)
    ) u_sflash_read_engine (
        .clk(clk), .rst_n(rst_n), .spi_sclk_i(sclk), .spi_csn_i(csn),
        .dq0_i(mosi), .busy_i(busy),
        .dq0_o(dq0), .dq0_oe_o(dq0_oe), .dq1_o(dq1), .dq1_oe_o(dq1_oe)
    );

    // Monitor: assemble bytes at serial rising edges and compare with the scoreboard.
    always @(posedge sclk) begin
        if (mon_en) begin
            if (!dq1_oe || (mon_dual && !dq0_oe)) mon_oe_bad = 1'b1;
            if (mon_dual) begin
                mon_sh   = {mon_sh[5:0], dq1, dq0};
                mon_bits = mon_bits + 2;
            end else begin
                mon_sh   = {mon_sh[6:0], dq1};
                mon_bits = mon_bits + 1;
            end
            if (mon_bits == 8) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL unexpected byte act=%02h exp=none", mon_sh);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (mon_sh !== e || mon_oe_bad) begin
                        failures++;
                        $display("FAIL %s byte act=%02h exp=%02h oe_ok=%0d", t, mon_sh, e, !mon_oe_bad);
                    end
                end
                mon_bits   = 0;
                mon_oe_bad = 1'b0;
            end
        end
    end

    task automatic tick_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        sclk = 1'b0;
        mosi = b;
        tick_half();
        sclk = 1'b1;
        tick_half();
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
    endtask

    task automatic begin_txn(input bit mode3);
        sclk = mode3;
        tick_half();
        csn = 1'b0;
        tick_half();
    endtask

    // Ends a transfer and checks both lines are released (R1).
    task automatic end_txn(input bit mode3, input string tag);
        if (!mode3) sclk = 1'b0;
        tick_half();
        csn = 1'b1;
        tick_half();
        tick_half();
        checks++;
        if (dq1_oe !== 1'b0 || dq0_oe !== 1'b0) begin
            failures++;
            $display("FAIL R1 (%s) release act=%0b%0b exp=00", tag, dq1_oe, dq0_oe);
        end
    endtask

    task automatic push_exp(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Driver: queue expected array bytes, then run an addressed read.
    task automatic do_read(input logic [7:0] op, input logic [23:0] addr, input int ndummy,
                           input int nbytes, input bit dual, input bit mode3, input string tag);
        for (int i = 0; i < nbytes; i++)
            push_exp(8'(((int'(addr) & AMASK) + i) & AMASK) ^ KEY, tag);
        begin_txn(mode3);
        send_bits({24'h0, op}, 8);
        send_bits({8'h0, addr}, 24);
        if (ndummy > 0) send_bits(32'h0, ndummy);
        mon_dual = dual;
        mon_bits = 0;
        mon_en   = 1'b1;
        repeat (nbytes * (dual ? 4 : 8)) clk_bit(1'b0);
        mon_en = 1'b0;
        end_txn(mode3, tag);
    endtask

    // Instruction without address; caller has queued the expected bytes.
    task automatic do_noaddr(input logic [7:0] op, input int nbytes, input string tag);
        begin_txn(1'b0);
        send_bits({24'h0, op}, 8);
        mon_dual = 1'b0;
        mon_bits = 0;
        mon_en   = 1'b1;
        repeat (nbytes * 8) clk_bit(1'b0);
        mon_en = 1'b0;
        end_txn(1'b0, tag);
    endtask

    // Instruction that must produce no output at all.
    task automatic do_silent(input logic [7:0] op, input string tag);
        logic bad;
        bad = 1'b0;
        begin_txn(1'b0);
        send_bits({24'h0, op}, 8);
        for (int i = 0; i < 24; i++) begin
            clk_bit(1'b0);
            if (dq1_oe !== 1'b0 || dq0_oe !== 1'b0) bad = 1'b1;
        end
        checks++;
        if (bad) begin
            failures++;
            $display("FAIL %s silent op=%02h act=driven exp=released", tag, op);
        end
        end_txn(1'b0, tag);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (dq1_oe !== 1'b0 || dq0_oe !== 1'b0) begin
            failures++;
            $display("FAIL R1 in reset act=%0b%0b exp=00", dq1_oe, dq0_oe);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (dq1_oe !== 1'b0 || dq0_oe !== 1'b0) begin
            failures++;
            $display("FAIL R1 after reset act=%0b%0b exp=00", dq1_oe, dq0_oe);
        end

        do_read(8'h03, 24'h000010, 0, 4, 1'b0, 1'b0, "R3");
        do_read(8'h03, 24'h000020, 0, 3, 1'b0, 1'b1, "R2");
        do_read(8'h0B, 24'h000080, 8, 5, 1'b0, 1'b0, "R4");
        do_read(8'h3B, 24'h000033, 4, 4, 1'b1, 1'b0, "R5");
        do_read(8'h0B, 24'h0000FD, 8, 5, 1'b0, 1'b0, "R6");
        do_read(8'h03, 24'h0000FE, 0, 4, 1'b0, 1'b1, "R6");
        do_read(8'h03, 24'h5AC340, 0, 3, 1'b0, 1'b0, "R7");

        // R8: identification pair, repeating.
        push_exp(8'h20, "R8"); push_exp(8'h10, "R8");
        push_exp(8'h20, "R8"); push_exp(8'h10, "R8");
        do_noaddr(8'h9F, 4, "R8");

        // R9: one-byte signature, repeating.
        push_exp(8'h05, "R9"); push_exp(8'h05, "R9"); push_exp(8'h05, "R9");
        do_noaddr(8'hAB, 3, "R9");

        // R10: identification reads dropped while busy.
        busy = 1'b1;
        do_silent(8'h9F, "R10");
        do_silent(8'hAB, "R10");
        busy = 1'b0;
        push_exp(8'h05, "R10");
        do_noaddr(8'hAB, 1, "R10");

        // R11: unknown opcode ignored.
        do_silent(8'h55, "R11");

        // R1: aborted instruction, then a fresh read decodes cleanly.
        begin_txn(1'b0);
        send_bits(32'h5, 3);
        end_txn(1'b0, "R1");
        do_read(8'h03, 24'h000001, 0, 2, 1'b0, 1'b0, "R1");

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3 leftover act=%0d exp=0", exp_q.size());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule